// File: doc/BRIEF.md
# Three-Share Masked Serial Adder

This block adds two words modulo 2^WIDTH without ever forming either operand in the clear. Each operand enters as three Boolean shares, and the true value is the XOR of the three. The three shares are packed into one port of 3*WIDTH bits, with share k in bits [k*WIDTH +: WIDTH]. The adder is a bit-serial ripple-carry circuit. Each clock it consumes the least significant remaining bit of every share. It produces one sum bit per share, and it updates three carry-share registers through a threshold-style majority function. No component of that function ever sees all three shares of its inputs.

A one-cycle start strobe loads both operands, a fresh batch of random bits and, when enabled, a three-share carry-in. That carry-in is normally the carry-out shares of the previous limb, so wider values can be added limb by limb. The sum and carry-out shares are always visible on the outputs. A caller may therefore issue its retrieve at any time. A caller that waits WIDTH cycles after the start gets the finished result. A caller that reads earlier sees a partial sum that is correct so far. The carry-out shares are meant only to be fed back as the next carry-in.

Top module: `masked_serial_adder`

## Requirements
- R1: After reset, busy_o is 0 and every bit of sum_o and cout_o is 0.
- R2: A start strobe sets busy_o on the next cycle. busy_o then stays high for exactly WIDTH clock cycles and falls at the end of the WIDTH-th bit step.
- R3: When busy_o falls, the XOR of the three WIDTH-bit sum shares (share k at bits [k*WIDTH +: WIDTH]) equals (A + B + C) mod 2^WIDTH. Here A and B are the XOR of the operand shares, and C is the XOR of the three cin_i bits when cin_en_i is 1 and 0 otherwise.
- R4: When busy_o falls, the XOR of the three cout_o bits equals bit WIDTH of A + B + C.
- R5: With cin_en_i at 0 during start, the value on cin_i has no effect on the result.
- R6: After n bit steps, the XOR of the sum shares shifted right by WIDTH-n equals the low n bits of A + B + C.
- R7: The recombined result does not depend on how the operands are split into shares or on the value of rand_i.
- R8: While idle and without a start, sum_o and cout_o hold their values whatever the other inputs do.
- R9: A start during an operation abandons it and begins a full WIDTH-step operation on the newly presented operands.
- R10: rand_i is sampled only at start (RAND_BITS bits per operation). Changing it during an operation leaves every output share bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load operands and begin an addition |
| cin_en_i | input | 1 | Use cin_i as carry-in (else carry-in is zero) |
| a_i | input | 3*WIDTH | First operand, three shares |
| b_i | input | 3*WIDTH | Second operand, three shares |
| cin_i | input | 3 | Carry-in, one bit per share |
| rand_i | input | RAND_BITS | Fresh random bits for carry remasking |
| busy_o | output | 1 | Addition in progress |
| sum_o | output | 3*WIDTH | Current sum shares |
| cout_o | output | 3 | Current carry shares / carry-out |

## Verification
The bench builds two instances: the default 32-bit adder and a 4-bit adder, both with four random bits. The 4-bit one allows every operand pair to be swept with both carry-in values, each with fresh share splits and randomness, which exercises every carry pattern through the masked majority. The 32-bit instance covers long carry chains, the timing of busy, partial reads in the middle of an operation, restart, and the checks that rand_i and cin_i are ignored.

// File: rtl/msa_pkg.sv
package msa_pkg;

   localparam int SHARES = 3;

   typedef logic [SHARES-1:0] share_bits_t;

   // one share of the masked product x*y, built only from shares j and k
   function automatic logic masked_and_part(share_bits_t x, share_bits_t y, int j, int k);
      return (x[j] & y[j]) ^ (x[j] & y[k]) ^ (x[k] & y[j]);
   endfunction

endpackage

// File: rtl/msa_carry_share.sv
module msa_carry_share
   import msa_pkg::*;
#(
   parameter int IDX = 0
) (
   input  share_bits_t a_i,
   input  share_bits_t b_i,
   input  share_bits_t c_i,
   output logic        c_o
);
   localparam int J = (IDX + 1) % SHARES;
   localparam int K = (IDX + 2) % SHARES;

   if (IDX < 0 || IDX >= SHARES) begin : g_bad_idx
      $error("msa_carry_share: IDX out of range");
   end

   // majority(a,b,c) = ab ^ ac ^ bc, each product split over shares J and K only
   always_comb begin
      c_o = masked_and_part(a_i, b_i, J, K)
          ^ masked_and_part(a_i, c_i, J, K)
          ^ masked_and_part(b_i, c_i, J, K);
   end
endmodule

// File: rtl/msa_share_lane.sv
module msa_share_lane #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sum_bit_i,
   output logic             a_bit_o,
   output logic             b_bit_o,
   output logic [WIDTH-1:0] sum_o
);
   logic [WIDTH-1:0] a_q, b_q, s_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         s_q <= '0;
      end else if (load_i) begin
         a_q <= a_i;
         b_q <= b_i;
         s_q <= '0;
      end else if (step_i) begin
         a_q <= a_q >> 1;
         b_q <= b_q >> 1;
         s_q <= {sum_bit_i, s_q[WIDTH-1:1]};
      end
   end

   assign a_bit_o = a_q[0];
   assign b_bit_o = b_q[0];
   assign sum_o   = s_q;
endmodule

// File: rtl/msa_ctrl.sv
module msa_ctrl
   import msa_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int RAND_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [RAND_BITS-1:0] rand_i,
   output logic                 busy_o,
   output logic                 step_o,
   output share_bits_t          mask_o
);
   localparam int CW = $clog2(WIDTH + 1);

   logic [CW-1:0]        cnt_q;
   logic [RAND_BITS-1:0] rnd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rnd_q <= '0;
      end else if (start_i) begin
         cnt_q <= CW'(WIDTH);
         rnd_q <= rand_i;
      end else if (step_o) begin
         cnt_q <= cnt_q - 1'b1;
         rnd_q <= {rnd_q[0], rnd_q[RAND_BITS-1:1]};
      end
   end

   assign busy_o = (cnt_q != '0);
   assign step_o = busy_o & ~start_i;
   // three masks whose XOR is zero, so the carry value is preserved
   assign mask_o = {rnd_q[0] ^ rnd_q[1], rnd_q[1], rnd_q[0]};
endmodule

// File: rtl/masked_serial_adder.sv
module masked_serial_adder
   import msa_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int RAND_BITS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    cin_en_i,
   input  logic [3*WIDTH-1:0]      a_i,
   input  logic [3*WIDTH-1:0]      b_i,
   input  logic [2:0]              cin_i,
   input  logic [RAND_BITS-1:0]    rand_i,
   output logic                    busy_o,
   output logic [3*WIDTH-1:0]      sum_o,
   output logic [2:0]              cout_o
);
   if (SHARES != 3) begin : g_bad_shares
      $error("masked_serial_adder: port layout assumes three shares");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("masked_serial_adder: WIDTH must be at least 2");
   end
   if (RAND_BITS < 2) begin : g_bad_rand
      $error("masked_serial_adder: RAND_BITS must be at least 2");
   end

   logic        step;
   share_bits_t mask;
   share_bits_t abit, bbit, sbit, carry_q, carry_d;

   msa_ctrl #(
      .WIDTH    (WIDTH),
      .RAND_BITS(RAND_BITS)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .rand_i (rand_i),
      .busy_o (busy_o),
      .step_o (step),
      .mask_o (mask)
   );

   for (genvar s = 0; s < SHARES; s++) begin : g_share
      assign sbit[s] = abit[s] ^ bbit[s] ^ carry_q[s];

      msa_share_lane #(
         .WIDTH(WIDTH)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_i   (start_i),
         .step_i   (step),
         .a_i      (a_i[s*WIDTH +: WIDTH]),
         .b_i      (b_i[s*WIDTH +: WIDTH]),
         .sum_bit_i(sbit[s]),
         .a_bit_o  (abit[s]),
         .b_bit_o  (bbit[s]),
         .sum_o    (sum_o[s*WIDTH +: WIDTH])
      );

      msa_carry_share #(
         .IDX(s)
      ) u_carry (
         .a_i(abit),
         .b_i(bbit),
         .c_i(carry_q),
         .c_o(carry_d[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= '0;
      end else if (start_i) begin
         carry_q <= cin_en_i ? cin_i : '0;
      end else if (step) begin
         carry_q <= carry_d ^ mask;
      end
   end

   assign cout_o = carry_q;
endmodule

// File: rtl/msa_checker.sv
module msa_checker #(
   parameter int WIDTH     = 32,
   parameter int RAND_BITS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic                 cin_en_i,
   input logic [3*WIDTH-1:0]   a_i,
   input logic [3*WIDTH-1:0]   b_i,
   input logic [2:0]           cin_i,
   input logic [RAND_BITS-1:0] rand_i,
   input logic                 busy_o,
   input logic [3*WIDTH-1:0]   sum_o,
   input logic [2:0]           cout_o
);
   localparam int CW = $clog2(WIDTH + 1);

   logic [CW-1:0]  ccnt;
   logic [WIDTH:0] exp_q;
   logic [WIDTH-1:0] fa, fb, fs;

   assign fa = a_i[0 +: WIDTH] ^ a_i[WIDTH +: WIDTH] ^ a_i[2*WIDTH +: WIDTH];
   assign fb = b_i[0 +: WIDTH] ^ b_i[WIDTH +: WIDTH] ^ b_i[2*WIDTH +: WIDTH];
   assign fs = sum_o[0 +: WIDTH] ^ sum_o[WIDTH +: WIDTH] ^ sum_o[2*WIDTH +: WIDTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccnt  <= '0;
         exp_q <= '0;
      end else if (start_i) begin
         ccnt  <= CW'(WIDTH);
         exp_q <= {1'b0, fa} + {1'b0, fb} + (WIDTH + 1)'(cin_en_i & ^cin_i);
      end else if (ccnt != '0) begin
         ccnt <= ccnt - 1'b1;
      end
   end

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);

   p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ccnt > CW'(1) && !start_i) |=> busy_o);

   p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ccnt == CW'(1) && !start_i) |=> !busy_o);

   p_sum_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ccnt == CW'(1) && !start_i) |=> (fs == exp_q[WIDTH-1:0]));

   p_carry_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ccnt == CW'(1) && !start_i) |=> ((^cout_o) == exp_q[WIDTH]));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(sum_o) && $stable(cout_o)));
endmodule

bind masked_serial_adder msa_checker #(
   .WIDTH    (WIDTH),
   .RAND_BITS(RAND_BITS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .cin_en_i(cin_en_i),
   .a_i     (a_i),
   .b_i     (b_i),
   .cin_i   (cin_i),
   .rand_i  (rand_i),
   .busy_o  (busy_o),
   .sum_o   (sum_o),
   .cout_o  (cout_o)
);

// File: tb/masked_serial_adder_tb.sv
module masked_serial_adder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 32;
   localparam int WS = 4;

   logic clk = 1'b0;
   logic rst_n;
   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int bad   = 0;

   logic          st32, cen32, busy32;
   logic [3*W-1:0] a32, b32, sum32;
   logic [2:0]    cin32, cout32;
   logic [3:0]    rnd32;

   logic           st4, cen4, busy4;
   logic [3*WS-1:0] a4, b4, sum4;
   logic [2:0]     cin4, cout4;
   logic [3:0]     rnd4;

   masked_serial_adder #(.WIDTH(W), .RAND_BITS(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(st32), .cin_en_i(cen32),
      .a_i(a32), .b_i(b32), .cin_i(cin32), .rand_i(rnd32),
      .busy_o(busy32), .sum_o(sum32), .cout_o(cout32));

   masked_serial_adder #(.WIDTH(WS), .RAND_BITS(4)) u_dut4 (
      .clk(clk), .rst_n(rst_n), .start_i(st4), .cin_en_i(cen4),
      .a_i(a4), .b_i(b4), .cin_i(cin4), .rand_i(rnd4),
      .busy_o(busy4), .sum_o(sum4), .cout_o(cout4));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] fold32(input logic [3*W-1:0] v);
      return v[0 +: W] ^ v[W +: W] ^ v[2*W +: W];
   endfunction

   function automatic logic [WS-1:0] fold4(input logic [3*WS-1:0] v);
      return v[0 +: WS] ^ v[WS +: WS] ^ v[2*WS +: WS];
   endfunction

   task automatic kick32(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic cv, input logic cen, input logic [3:0] rv);
      logic [W-1:0] m0 = $urandom, m1 = $urandom, n0 = $urandom, n1 = $urandom;
      logic r0 = 1'($urandom), r1 = 1'($urandom);
      @(negedge clk);
      a32   = {av ^ m0 ^ m1, m1, m0};
      b32   = {bv ^ n0 ^ n1, n1, n0};
      cin32 = {cv ^ r0 ^ r1, r1, r0};
      cen32 = cen;
      rnd32 = rv;
      st32  = 1'b1;
      @(negedge clk);
      st32  = 1'b0;
   endtask

   // full operation with busy timing, a partial read and the final result
   task automatic op32(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input logic cen, input logic [3:0] rv, input string tag);
      logic [W:0] full = {1'b0, av} + {1'b0, bv} + (W + 1)'(cv & cen);
      kick32(av, bv, cv, cen, rv);
      repeat (W/2) @(negedge clk);
      chk({"R6 partial ", tag}, 64'(fold32(sum32) >> (W/2)), 64'(full[W/2-1:0]));
      repeat (W/2 - 1) @(negedge clk);
      chk({"R2 busy high ", tag}, 64'(busy32), 64'(1));
      @(negedge clk);
      chk({"R2 busy low ", tag}, 64'(busy32), 64'(0));
      chk({"R3 sum ", tag}, 64'(fold32(sum32)), 64'(full[W-1:0]));
      chk({"R4 cout ", tag}, 64'(^cout32), 64'(full[W]));
   endtask

   task automatic op4(input logic [WS-1:0] av, input logic [WS-1:0] bv, input logic cv);
      logic [WS-1:0] m0 = 4'($urandom), m1 = 4'($urandom), n0 = 4'($urandom), n1 = 4'($urandom);
      logic r0 = 1'($urandom), r1 = 1'($urandom);
      logic [WS:0] full = {1'b0, av} + {1'b0, bv} + (WS + 1)'(cv);
      @(negedge clk);
      a4   = {av ^ m0 ^ m1, m1, m0};
      b4   = {bv ^ n0 ^ n1, n1, n0};
      cin4 = {cv ^ r0 ^ r1, r1, r0};
      cen4 = 1'b1;
      rnd4 = 4'($urandom);
      st4  = 1'b1;
      @(negedge clk);
      st4  = 1'b0;
      repeat (WS) @(negedge clk);
      chk("R2 busy low w4", 64'(busy4), 64'(0));
      chk("R3 sum w4", 64'(fold4(sum4)), 64'(full[WS-1:0]));
      chk("R4 cout w4", 64'(^cout4), 64'(full[WS]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [3*W-1:0] keep_s;
      logic [2:0]     keep_c;
      rst_n = 1'b0;
      st32 = 0; cen32 = 0; a32 = '0; b32 = '0; cin32 = '0; rnd32 = '0;
      st4 = 0; cen4 = 0; a4 = '0; b4 = '0; cin4 = '0; rnd4 = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 64'(busy32), 64'(0));
      chk("R1 sum", 64'(sum32 != '0), 64'(0));
      chk("R1 cout", 64'(cout32), 64'(0));
      chk("R1 sum w4", 64'(sum4), 64'(0));

      op32(32'h0, 32'h0, 1'b0, 1'b1, 4'h3, "zero");
      op32(32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, 4'h9, "wrap");
      op32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'hC, "allones cin");
      op32(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 4'h5, "msb carry");
      // R5 carry-in ignored when not enabled
      op32(32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 4'h7, "R5 cin off");
      op32(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b0, 4'hA, "R5 cin off2");
      for (int i = 0; i < 20; i++)
         op32($urandom, $urandom, 1'($urandom), 1'($urandom), 4'($urandom), "random");
      // R7 different splits and randomness, same values
      for (int i = 0; i < 4; i++)
         op32(32'hDEAD_BEEF, 32'h2152_4111, 1'b1, 1'b1, 4'(i * 5), "R7 resplit");

      // R8 idle outputs hold
      keep_s = sum32;
      keep_c = cout32;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         a32 = {$urandom, $urandom, $urandom};
         b32 = {$urandom, $urandom, $urandom};
         cin32 = 3'($urandom);
         cen32 = 1'($urandom);
         rnd32 = 4'($urandom);
      end
      @(negedge clk);
      chk("R8 sum hold", 64'(sum32 == keep_s), 64'(1));
      chk("R8 cout hold", 64'(cout32), 64'(keep_c));

      // R9 restart mid-operation
      kick32(32'h1111_1111, 32'h2222_2222, 1'b0, 1'b1, 4'h1);
      repeat (10) @(negedge clk);
      begin
         logic [W:0] full = {1'b0, 32'hF0F0_F0F0} + {1'b0, 32'h1F1F_1F1F} + 33'd1;
         kick32(32'hF0F0_F0F0, 32'h1F1F_1F1F, 1'b1, 1'b1, 4'h2);
         repeat (W - 1) @(negedge clk);
         chk("R9 busy after restart", 64'(busy32), 64'(1));
         @(negedge clk);
         chk("R9 busy end", 64'(busy32), 64'(0));
         chk("R9 sum", 64'(fold32(sum32)), 64'(full[W-1:0]));
         chk("R9 cout", 64'(^cout32), 64'(full[W]));
      end

      // R10 rand_i only sampled at start
      kick32(32'hCAFE_F00D, 32'h0BAD_C0DE, 1'b1, 1'b1, 4'h6);
      repeat (W) @(negedge clk);
      keep_s = sum32;
      keep_c = cout32;
      st32 = 1'b1;
      @(negedge clk);
      st32 = 1'b0;
      for (int i = 0; i < W; i++) begin
         rnd32 = 4'($urandom);
         @(negedge clk);
      end
      chk("R10 sum shares", 64'(sum32 == keep_s), 64'(1));
      chk("R10 cout shares", 64'(cout32), 64'(keep_c));

      // exhaustive sweep on the narrow instance (R3, R4, R7)
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++)
               op4(4'(a), 4'(b), 1'(c));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule